// File: doc/BRIEF.md
# Two-Pass 8x8 Transform Transpose Sequencer

This block sequences a separable two-dimensional 8x8 transform around an external one-dimensional transform unit. It holds two 64-word buffers that can be inferred as block RAM. In the first pass the unit delivers row results, and the block stores them in row-major order in the first buffer. In the second pass it reads that buffer back in column-major order, which transposes the block, and feeds the words to the unit. At the same time it stores the unit's column results in the second buffer. In the third pass it reads the second buffer column-major and presents the final block, saturated to the output word size.

Each buffer access lasts one cycle, so every pass lasts 64 cycles. The enables follow a fixed order: write buffer 1; then read buffer 1 and write buffer 2 together; then read buffer 2. A mode bit is sampled when a block starts and selects the forward or the inverse transform. The block tells the unit which one to use through a coefficient-transpose flag, because the inverse applies the transposed coefficient matrix in both passes. The mode also selects how far the final words are saturated.

Top module: `dct2d_transpose_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `busy`, `done`, all four buffer enables, `pass_sel`, `xu_rd_valid` and `blk_valid` are 0. A reset in the middle of a block abandons it.
- R2: A `start` seen while idle starts a block on the next cycle. For 64 cycles only `buf1_we` is high, and `buf_wr_addr` counts from 0 to 63 in row-major order (address = row*8 + column).
- R3: The second pass follows at once. For 64 cycles `buf1_re` and `buf2_we` are high together and no other enable is high. `buf_wr_addr` counts from 0 to 63, and on transfer k `buf_rd_addr` is (k mod 8)*8 + k/8.
- R4: One cycle after each second-pass read, `xu_rd_valid` is high and `xu_rd_data` holds the word that the first pass wrote at that read address.
- R5: The third pass follows at once. For 64 cycles only `buf2_re` is high, and `buf_rd_addr` follows the same column-major order as in R3.
- R6: Two cycles after each third-pass read, `blk_valid` is high. In forward mode `blk_data` is the stored signed 11-bit word clipped to the signed 9-bit range [-256, 255].
- R7: In inverse mode the stored word is clipped to the signed 8-bit range [-128, 127] and sign-extended onto the 9-bit `blk_data`.
- R8: `coef_transpose` takes the value of `inverse` when a start is accepted and holds it until the block ends, whatever `inverse` does in between. `pass_sel` is 1 exactly during the second pass.
- R9: `done` is a single-cycle pulse in the cycle after the last `blk_valid`. `busy` is high from the first cycle of the first pass through the `done` cycle.
- R10: A `start` seen while `busy` is high, including the `done` cycle, has no effect. The next `start` seen while idle begins a fresh block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a block |
| inverse | input | 1 | 1 selects the inverse transform; sampled when a start is accepted |
| in_wr_data | input | DW (11) | Result word from the transform unit, written in passes 1 and 2 |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle end-of-block pulse |
| coef_transpose | output | 1 | Tells the unit to use the transposed coefficient matrix |
| pass_sel | output | 1 | 0 during the row pass, 1 during the column pass |
| buf1_we | output | 1 | Buffer 1 write enable |
| buf1_re | output | 1 | Buffer 1 read enable |
| buf2_we | output | 1 | Buffer 2 write enable |
| buf2_re | output | 1 | Buffer 2 read enable |
| buf_wr_addr | output | 6 | Row-major write address |
| buf_rd_addr | output | 6 | Column-major read address |
| xu_rd_data | output | DW (11) | Transposed word fed to the unit |
| xu_rd_valid | output | 1 | `xu_rd_data` is valid |
| blk_data | output | OW (9) | Final saturated result word |
| blk_valid | output | 1 | `blk_data` is valid |

## Verification
The assertions take the transform unit to be a stream with no back-pressure: one word of `in_wr_data` per cycle in each pass. Any write data is accepted. The assertions assume nothing about when `start` or `inverse` change. The stimulus therefore sends bit patterns that fall inside and outside both clip ranges, raises `start` in the middle of a block and in the `done` cycle, and flips `inverse` right after a block is accepted. The only input ordering the assertions rely on is a synchronous reset, and the stimulus also applies one in the middle of a block.

// File: rtl/dct_tp_pkg.sv
package dct_tp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ROWS,
    S_COLS,
    S_DRAIN,
    S_FLUSH
  } tp_state_e;

  // one-hot buffer-enable phase: bit0 = write buf1, bit1 = read buf1 / write buf2,
  // bit2 = read buf2
  function automatic logic [2:0] phase_of(tp_state_e s);
    case (s)
      S_ROWS:  return 3'b001;
      S_COLS:  return 3'b010;
      S_DRAIN: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/tp_ram.sv
module tp_ram #(
  parameter int DW    = 11,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/tp_seq.sv
module tp_seq
  import dct_tp_pkg::*;
#(
  parameter int N  = 8,
  localparam int DEPTH = N * N,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          inverse,
  input  logic          flush_done,
  output logic [2:0]    phase_q,
  output logic          busy_q,
  output logic          coef_tr_q,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          last_rd
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  tp_state_e     state_q, state_d;
  logic [AW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (start)      state_d = S_ROWS;
      S_ROWS:  if (at_last)    state_d = S_COLS;
      S_COLS:  if (at_last)    state_d = S_DRAIN;
      S_DRAIN: if (at_last)    state_d = S_FLUSH;
      S_FLUSH: if (flush_done) state_d = S_IDLE;
      default:                 state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      phase_q   <= '0;
      busy_q    <= 1'b0;
      coef_tr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_of(state_d);
      busy_q  <= (state_d != S_IDLE);
      if (state_q == S_IDLE && start) coef_tr_q <= inverse;
      if (phase_of(state_q) != 3'b000) cnt_q <= cnt_q + AW'(1);
      else                             cnt_q <= '0;
    end
  end

  // writes are row-major (identity); reads swap row and column index fields
  assign wr_addr = cnt_q;
  assign rd_addr = {cnt_q[LW-1:0], cnt_q[AW-1:LW]};
  assign last_rd = phase_q[2] && at_last;

  a_r2_onehot_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phase_q));
  a_r2_enter_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_q[0]) |-> $past(start) && !$past(busy_q));
  a_r3_cols_after_rows: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_q[1]) |-> $past(phase_q[0]) && ($past(cnt_q) == LAST));
  a_r5_drain_after_cols: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_q[2]) |-> $past(phase_q[1]));
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (phase_q != 3'b000) && $past(phase_q != 3'b000) && (cnt_q != '0)
      |-> cnt_q == $past(cnt_q) + AW'(1));
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
    busy_q && $past(busy_q) |-> $stable(coef_tr_q));
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    start && busy_q |=> $stable(coef_tr_q) && !$rose(phase_q[0]));

endmodule

// File: rtl/tp_outstage.sv
module tp_outstage #(
  parameter int DW    = 11,
  parameter int OW    = 9,
  parameter int INV_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          rd_last,
  input  logic          inv,
  input  logic [DW-1:0] raw,
  output logic [OW-1:0] blk_data,
  output logic          blk_valid,
  output logic          done
);

  localparam int FHI = (1 << (OW - 1)) - 1;
  localparam int FLO = -(1 << (OW - 1));
  localparam int IHI = (1 << (INV_W - 1)) - 1;
  localparam int ILO = -(1 << (INV_W - 1));

  logic               v1_q, l1_q, l2_q;
  logic signed [31:0] wide_v, clip_v;
  int                 hi, lo;

  always_comb begin
    wide_v = 32'(signed'(raw));
    hi     = inv ? IHI : FHI;
    lo     = inv ? ILO : FLO;
    if (wide_v > hi)      clip_v = hi;
    else if (wide_v < lo) clip_v = lo;
    else                  clip_v = wide_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      l1_q      <= 1'b0;
      l2_q      <= 1'b0;
      blk_valid <= 1'b0;
      done      <= 1'b0;
      blk_data  <= '0;
    end else begin
      v1_q      <= rd_en;
      l1_q      <= rd_last;
      blk_valid <= v1_q;
      l2_q      <= l1_q;
      done      <= l2_q;
      if (v1_q) blk_data <= clip_v[OW-1:0];
    end
  end

  a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> $past(rd_en, 2));
  a_r7_inverse_range: assert property (@(posedge clk) disable iff (rst)
    blk_valid && inv |-> (32'(signed'(blk_data)) <= IHI) && (32'(signed'(blk_data)) >= ILO));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(blk_valid) && !blk_valid);

endmodule

// File: rtl/dct2d_transpose_ctrl.sv
module dct2d_transpose_ctrl #(
  parameter int N     = 8,
  parameter int DW    = 11,
  parameter int OW    = 9,
  parameter int INV_W = 8,
  localparam int DEPTH = N * N,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          inverse,
  input  logic [DW-1:0] in_wr_data,
  output logic          busy,
  output logic          done,
  output logic          coef_transpose,
  output logic          pass_sel,
  output logic          buf1_we,
  output logic          buf1_re,
  output logic          buf2_we,
  output logic          buf2_re,
  output logic [AW-1:0] buf_wr_addr,
  output logic [AW-1:0] buf_rd_addr,
  output logic [DW-1:0] xu_rd_data,
  output logic          xu_rd_valid,
  output logic [OW-1:0] blk_data,
  output logic          blk_valid
);

  logic [2:0]    phase;
  logic          last_rd;
  logic [DW-1:0] ram2_q;

  tp_seq #(.N(N)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .inverse    (inverse),
    .flush_done (done),
    .phase_q    (phase),
    .busy_q     (busy),
    .coef_tr_q  (coef_transpose),
    .wr_addr    (buf_wr_addr),
    .rd_addr    (buf_rd_addr),
    .last_rd    (last_rd)
  );

  assign buf1_we  = phase[0];
  assign buf1_re  = phase[1];
  assign buf2_we  = phase[1];
  assign buf2_re  = phase[2];
  assign pass_sel = phase[1];

  tp_ram #(.DW(DW), .DEPTH(DEPTH)) ram_row_i (
    .clk   (clk),
    .we    (buf1_we),
    .waddr (buf_wr_addr),
    .wdata (in_wr_data),
    .re    (buf1_re),
    .raddr (buf_rd_addr),
    .rdata (xu_rd_data)
  );

  tp_ram #(.DW(DW), .DEPTH(DEPTH)) ram_col_i (
    .clk   (clk),
    .we    (buf2_we),
    .waddr (buf_wr_addr),
    .wdata (in_wr_data),
    .re    (buf2_re),
    .raddr (buf_rd_addr),
    .rdata (ram2_q)
  );

  always_ff @(posedge clk) begin
    if (rst) xu_rd_valid <= 1'b0;
    else     xu_rd_valid <= buf1_re;
  end

  tp_outstage #(.DW(DW), .OW(OW), .INV_W(INV_W)) out_i (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (buf2_re),
    .rd_last   (last_rd),
    .inv       (coef_transpose),
    .raw       (ram2_q),
    .blk_data  (blk_data),
    .blk_valid (blk_valid),
    .done      (done)
  );

  a_r4_feed_valid: assert property (@(posedge clk) disable iff (rst)
    xu_rd_valid |-> $past(buf1_re));
  a_r3_no_read_while_fill: assert property (@(posedge clk) disable iff (rst)
    buf1_we |-> !buf2_re && !xu_rd_valid);
  a_r9_busy_covers_output: assert property (@(posedge clk) disable iff (rst)
    (blk_valid || done) |-> busy);

endmodule

// File: tb/dct2d_transpose_ctrl_tb.sv
module dct2d_transpose_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        inverse = 1'b0;
  logic [10:0] in_wr_data = '0;
  logic        busy, done, coef_transpose, pass_sel;
  logic        buf1_we, buf1_re, buf2_we, buf2_re;
  logic [5:0]  buf_wr_addr, buf_rd_addr;
  logic [10:0] xu_rd_data;
  logic        xu_rd_valid;
  logic [8:0]  blk_data;
  logic        blk_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dct2d_transpose_ctrl dut_i (
    .clk(clk), .rst(rst), .start(start), .inverse(inverse), .in_wr_data(in_wr_data),
    .busy(busy), .done(done), .coef_transpose(coef_transpose), .pass_sel(pass_sel),
    .buf1_we(buf1_we), .buf1_re(buf1_re), .buf2_we(buf2_we), .buf2_re(buf2_re),
    .buf_wr_addr(buf_wr_addr), .buf_rd_addr(buf_rd_addr),
    .xu_rd_data(xu_rd_data), .xu_rd_valid(xu_rd_valid),
    .blk_data(blk_data), .blk_valid(blk_valid)
  );

  // {inverse, raw 11-bit word at address 0 of pass-2 data, expected first output}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 11'h064, 9'h064},   // forward, in range: 100
    {1'b0, 11'h12C, 9'h0FF},   // forward, 300 clips to 255
    {1'b0, 11'h6D4, 9'h100},   // forward, -300 clips to -256
    {1'b0, 11'h700, 9'h100},   // forward, -256 exactly
    {1'b1, 11'h064, 9'h064},   // inverse, 100
    {1'b1, 11'h0C8, 9'h07F},   // inverse, 200 clips to 127
    {1'b1, 11'h738, 9'h180},   // inverse, -200 clips to -128
    {1'b1, 11'h7FB, 9'h1FB}    // inverse, -5 sign-extended
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int d1(input int base, input int k);
    return (base + k * 37) & 'h7FF;
  endfunction

  function automatic int d2(input int raw, input int k);
    return (raw + k * 29) & 'h7FF;
  endfunction

  function automatic int cmv(input int k);
    return (k % 8) * 8 + k / 8;
  endfunction

  function automatic int clip(input int v11, input bit inv);
    int sv = (v11 >= 1024) ? v11 - 2048 : v11;
    int hi = inv ? 127 : 255;
    int lo = inv ? -128 : -256;
    if (sv > hi) sv = hi;
    if (sv < lo) sv = lo;
    return sv & 'h1FF;
  endfunction

  task automatic run_block(input bit inv, input int base1, input int raw, input int exp0);
    @(negedge clk);
    start   = 1'b1;
    inverse = inv;
    for (int t = 0; t <= 196; t++) begin
      @(negedge clk);
      chk("R9 busy", busy, (t <= 194) ? 1 : 0);
      chk("R9 done", done, (t == 194) ? 1 : 0);
      chk("R2 buf1_we", buf1_we, (t < 64) ? 1 : 0);
      chk("R3 buf1_re", buf1_re, (t >= 64 && t < 128) ? 1 : 0);
      chk("R3 buf2_we", buf2_we, (t >= 64 && t < 128) ? 1 : 0);
      chk("R5 buf2_re", buf2_re, (t >= 128 && t < 192) ? 1 : 0);
      chk("R8 pass_sel", pass_sel, (t >= 64 && t < 128) ? 1 : 0);
      if (t <= 194) chk("R8 coef_transpose", coef_transpose, inv);
      if (t < 64) chk("R2 wr_addr", buf_wr_addr, t);
      if (t >= 64 && t < 128) begin
        chk("R3 wr_addr", buf_wr_addr, t - 64);
        chk("R3 rd_addr", buf_rd_addr, cmv(t - 64));
      end
      if (t >= 128 && t < 192) chk("R5 rd_addr", buf_rd_addr, cmv(t - 128));
      chk("R4 xu_rd_valid", xu_rd_valid, (t >= 65 && t <= 128) ? 1 : 0);
      if (t >= 65 && t <= 128) chk("R4 xu_rd_data", xu_rd_data, d1(base1, cmv(t - 65)));
      chk("R6 blk_valid", blk_valid, (t >= 130 && t <= 193) ? 1 : 0);
      if (t >= 130 && t <= 193)
        chk(inv ? "R7 blk_data" : "R6 blk_data", blk_data, clip(d2(raw, cmv(t - 130)), inv));
      if (t == 130) chk(inv ? "R7 first word" : "R6 first word", blk_data, exp0);
      // drive this cycle's inputs
      inverse    = ~inv;                                // R8: changes after acceptance
      start      = (t == 50 || t == 194) ? 1'b1 : 1'b0; // R10: starts while busy
      in_wr_data = (t < 64) ? 11'(d1(base1, t)) : (t < 128) ? 11'(d2(raw, t - 64)) : 11'h0;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 enables in reset", {buf1_we, buf1_re, buf2_we, buf2_re}, 0);
    chk("R1 valids in reset", {xu_rd_valid, blk_valid, pass_sel}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", busy, 0);

    for (int i = 0; i < 8; i++)
      run_block(VEC[i][20], i * 100 + 7, int'(VEC[i][19:9]), int'(VEC[i][8:0]));

    // R10: start pulses during the previous block left the block idle
    chk("R10 idle after ignored starts", busy, 0);
    chk("R10 no refill after ignored start", buf1_we, 0);

    // R1: reset during the second pass abandons the block
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (70) @(negedge clk);
    chk("R3 mid-block second pass", buf1_re, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 busy after mid reset", busy, 0);
    chk("R1 enables after mid reset", {buf1_we, buf1_re, buf2_we, buf2_re}, 0);
    chk("R1 valids after mid reset", {xu_rd_valid, blk_valid, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 still idle", busy, 0);

    // R10: a fresh block after the abandoned one runs normally
    run_block(1'b0, 55, 'h3F0, clip('h3F0, 1'b0));

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule